// File: doc/BRIEF.md
# Two-Wire Slave Register Access Port

This block is the slave end of a two-wire serial bus (I2C-style, clock plus bidirectional data). It gives an external host read and write access to a bank of up to 128 byte-wide registers, which live outside the block behind a simple parallel interface. Both serial lines are brought into the system clock domain. The block recognises START, repeated START and STOP conditions. It answers only to the 7-bit device address set on static strap inputs.

A write transaction carries a pointer byte first. Bit 7 of that byte selects whether the pointer stands still or advances after each byte. Bits 6:0 pick the starting register. The pointer never wraps: once it reaches 127 it stays there. A STOP always returns it to zero, so a read sent with no pointer byte begins at register 0. To read from any other register, the host writes the pointer, issues a repeated START and then reads.

Top module: `twowire_regport`

## Requirements
- R1: The slave pulls data low (data enable 1) during the ninth clock of an address byte only when bits 7:1 of that byte equal `dev_addr_i`. On a mismatch it leaves the line released and ignores all later bytes, with no write or read strobe, until the next START or STOP.
- R2: In a write transaction (address byte bit 0 = 0), the first byte after the address loads the pointer. Each later byte produces a write strobe of exactly one cycle, with `reg_addr_o` equal to the current pointer and `reg_wdata_o` equal to the byte, assembled most significant bit first. Every byte of a write transaction is acknowledged.
- R3: When bit 7 of the pointer byte is 1, the pointer does not advance, so every following data byte lands in the same register.
- R4: When bit 7 of the pointer byte is 0, the pointer advances by one after each byte written or read. It saturates at 127, so the bytes that follow go to, or come from, register 127.
- R5: A STOP sets the pointer to 0, clears the inhibit flag and releases the data line.
- R6: A read transaction (address byte bit 0 = 1) that directly follows a STOP returns registers 0, 1, 2, ... in order.
- R7: A pointer write followed by a repeated START and a read address returns data starting at the register that was written into the pointer.
- R8: Each read byte is fetched with one read strobe, with `reg_addr_o` equal to that byte's register, and is sent most significant bit first. Data changes only while the clock is low.
- R9: When the host answers a read byte with NACK (data high on the ninth clock), the slave stops driving and issues no further read strobe until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| dev_addr_i | input | 7 | Strapped device address |
| reg_addr_o | output | 7 | Register address (the current pointer) |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data, combinational from `reg_addr_o` |
| reg_re_o | output | 1 | One-cycle read strobe; read data is captured in this cycle |

## Verification
The assertions assume the following about the host and the register bank:
- The host changes the data line only while the serial clock is low, except when it makes a START or STOP.
- Each clock phase lasts several system clocks longer than the synchroniser delay.
- The register bank returns read data in the same cycle as the address.

The bench master holds each quarter of a bit for eight system clocks and always ends a read with NACK before a STOP or repeated START. It sweeps every one of the 128 device addresses. It derives the expected register contents from a fixed arithmetic seed and from the bytes it writes itself.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TW_DEV_AW = 7;
  localparam int TW_DW     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } tw_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } tw_kind_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_m, sda_m;
  logic              scl_d, sda_d;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= '1;
      sda_m <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[STAGES-2:0], scl_i};
      sda_m <= {sda_m[STAGES-2:0], sda_i};
      scl_d <= scl_m[STAGES-1];
      sda_d <= sda_m[STAGES-1];
    end
  end

  assign scl_s     = scl_m[STAGES-1];
  assign sda_s     = sda_m[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/tw_ptr.sv
module tw_ptr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          load_inh,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] PMAX = {AW{1'b1}};

  logic          inh, inh_nx;
  logic [AW-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    inh_nx = inh;
    if (clr) begin
      ptr_nx = '0;
      inh_nx = 1'b0;
    end else if (load) begin
      ptr_nx = load_val;
      inh_nx = load_inh;
    end else if (adv && !inh && (ptr != PMAX)) begin
      ptr_nx = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      inh <= 1'b0;
    end else begin
      ptr <= ptr_nx;
      inh <= inh_nx;
    end
  end

  // R4: saturation at the top register
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == PMAX && adv && !load && !clr) |=> (ptr == PMAX));

  // R3: inhibit flag freezes the pointer
  a_r3_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inh && adv && !load && !clr) |=> $stable(ptr));

  // R5: stop returns the pointer to zero
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0));
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [TW_DEV_AW-1:0] dev_addr,
  input  logic [TW_DW-1:0]     reg_rdata,
  output logic                 sda_oe,
  output logic                 reg_we,
  output logic [TW_DW-1:0]     reg_wdata,
  output logic                 reg_re,
  output logic                 ptr_clr,
  output logic                 ptr_load,
  output logic                 ptr_load_inh,
  output logic [TW_DEV_AW-1:0] ptr_load_val,
  output logic                 ptr_adv
);
  tw_state_e        state, st_nx;
  tw_kind_e         kind, kd_nx;
  logic [3:0]       cnt, cnt_nx;
  logic [TW_DW-1:0] shreg, sh_nx;
  logic             rw, rw_nx;
  logic             ack_ok, ak_nx;
  logic             byte_done;

  assign byte_done = scl_fall && (cnt == 4'd8);

  always_comb begin
    st_nx    = state;
    kd_nx    = kind;
    cnt_nx   = cnt;
    sh_nx    = shreg;
    rw_nx    = rw;
    ak_nx    = ack_ok;
    reg_we   = 1'b0;
    reg_re   = 1'b0;
    ptr_load = 1'b0;
    ptr_adv  = 1'b0;
    if (stop_det) begin
      st_nx = ST_IDLE;
    end else if (start_det) begin
      st_nx  = ST_RX;
      kd_nx  = BK_ADDR;
      cnt_nx = '0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            sh_nx  = {shreg[TW_DW-2:0], sda_s};
            cnt_nx = cnt + 4'd1;
          end else if (byte_done) begin
            case (kind)
              BK_ADDR: begin
                if (shreg[TW_DW-1:1] == dev_addr) begin
                  rw_nx = shreg[0];
                  st_nx = ST_RACK;
                end else begin
                  st_nx = ST_IDLE;
                end
              end
              BK_PTR: begin
                ptr_load = 1'b1;
                st_nx    = ST_RACK;
              end
              default: begin
                reg_we  = 1'b1;
                ptr_adv = 1'b1;
                st_nx   = ST_RACK;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            cnt_nx = '0;
            if (kind == BK_ADDR && rw) begin
              st_nx   = ST_TX;
              sh_nx   = reg_rdata;
              reg_re  = 1'b1;
              ptr_adv = 1'b1;
            end else begin
              st_nx = ST_RX;
              kd_nx = (kind == BK_ADDR) ? BK_PTR : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st_nx = ST_TACK;
            end else begin
              sh_nx  = {shreg[TW_DW-2:0], 1'b0};
              cnt_nx = cnt + 4'd1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            ak_nx = ~sda_s;
          end else if (scl_fall) begin
            if (ack_ok) begin
              st_nx   = ST_TX;
              sh_nx   = reg_rdata;
              reg_re  = 1'b1;
              ptr_adv = 1'b1;
              cnt_nx  = '0;
            end else begin
              st_nx = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= BK_ADDR;
      cnt    <= '0;
      shreg  <= '0;
      rw     <= 1'b0;
      ack_ok <= 1'b0;
    end else begin
      state  <= st_nx;
      kind   <= kd_nx;
      cnt    <= cnt_nx;
      shreg  <= sh_nx;
      rw     <= rw_nx;
      ack_ok <= ak_nx;
    end
  end

  assign sda_oe       = (state == ST_RACK) | ((state == ST_TX) & ~shreg[TW_DW-1]);
  assign reg_wdata    = shreg;
  assign ptr_clr      = stop_det;
  assign ptr_load_inh = shreg[TW_DW-1];
  assign ptr_load_val = shreg[TW_DEV_AW-1:0];

  // R1: no acknowledge for a foreign address
  a_r1_mismatch_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX && kind == BK_ADDR && byte_done && !start_det && !stop_det &&
     shreg[TW_DW-1:1] != dev_addr) |=> !sda_oe);

  // R2: write strobe lasts a single cycle
  a_r2_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R9: host NACK ends the read
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TACK && scl_fall && !ack_ok && !start_det && !stop_det)
    |=> (!sda_oe && !reg_re));

  // R5: stop releases the data line
  a_r5_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

// File: rtl/twowire_regport.sv
module twowire_regport
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [TW_DEV_AW-1:0] dev_addr_i,
  output logic [TW_DEV_AW-1:0] reg_addr_o,
  output logic [TW_DW-1:0]     reg_wdata_o,
  output logic                 reg_we_o,
  input  logic [TW_DW-1:0]     reg_rdata_i,
  output logic                 reg_re_o
);
  logic [1:0]           rst_pipe;
  logic                 rst_int_n;
  logic                 sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                 ptr_clr, ptr_load, ptr_load_inh, ptr_adv;
  logic [TW_DEV_AW-1:0] ptr_load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_engine u_engine (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .dev_addr     (dev_addr_i),
    .reg_rdata    (reg_rdata_i),
    .sda_oe       (sda_oe),
    .reg_we       (reg_we_o),
    .reg_wdata    (reg_wdata_o),
    .reg_re       (reg_re_o),
    .ptr_clr      (ptr_clr),
    .ptr_load     (ptr_load),
    .ptr_load_inh (ptr_load_inh),
    .ptr_load_val (ptr_load_val),
    .ptr_adv      (ptr_adv)
  );

  tw_ptr #(.AW(TW_DEV_AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (ptr_clr),
    .load     (ptr_load),
    .load_inh (ptr_load_inh),
    .load_val (ptr_load_val),
    .adv      (ptr_adv),
    .ptr      (reg_addr_o)
  );
endmodule

// File: tb/twowire_regport_bench.sv
module twowire_regport_bench;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_bus;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  logic [7:0] mem [128];
  int         wr_cnt, rd_cnt;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  twowire_regport u_twowire_regport (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe      (sda_oe),
    .dev_addr_i  (DEV),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata),
    .reg_re_o    (reg_re)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= seed(i);
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_re) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_c(Q);
    scl_m = 1'b1; wait_c(Q);
    sda_m = 1'b0; wait_c(Q);
    scl_m = 1'b0; wait_c(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_c(Q);
    scl_m = 1'b1; wait_c(Q);
    sda_m = 1'b1; wait_c(2 * Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;    wait_c(Q);
    scl_m = 1'b1; wait_c(2 * Q);
    scl_m = 1'b0; wait_c(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wait_c(Q);
    scl_m = 1'b1; wait_c(Q);
    b = sda_bus;  wait_c(Q);
    scl_m = 1'b0; wait_c(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic read_byte(output logic [7:0] v, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      v[i] = x;
    end
    bit_out(~give_ack);
  endtask

  logic [7:0] rv;
  logic       ak;
  int         base;

  initial begin
    wait_c(4);
    rst_n = 1'b1;
    wait_c(6);

    // reset state
    check("R1 reset sda_oe", int'(sda_oe), 0);
    check("R2 reset we", int'(reg_we), 0);
    check("R8 reset re", int'(reg_re), 0);

    // R1: sweep all device addresses
    base = wr_cnt;
    for (int a = 0; a < 128; a++) begin
      bus_start;
      write_byte({7'(a), 1'b0}, ak);
      check("R1 address ack", int'(ak), (7'(a) == DEV) ? 1 : 0);
      if (7'(a) != DEV) begin
        write_byte(8'h05, ak);
        write_byte(8'h66, ak);
        check("R1 ignored data nack", int'(ak), 0);
      end
      bus_stop;
    end
    check("R1 no write on mismatch", wr_cnt - base, 0);
    check("R1 reg5 untouched", int'(mem[5]), int'(seed(5)));

    // R2 R4: incrementing write
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'h10, ak);
    check("R2 pointer byte ack", int'(ak), 1);
    write_byte(8'hA5, ak);
    write_byte(8'h3C, ak);
    write_byte(8'hE1, ak);
    check("R2 data ack", int'(ak), 1);
    bus_stop;
    check("R2 mem16", int'(mem[16]), 'hA5);
    check("R4 mem17", int'(mem[17]), 'h3C);
    check("R4 mem18", int'(mem[18]), 'hE1);

    // R3: inhibit
    base = wr_cnt;
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'hA0, ak);
    write_byte(8'h11, ak);
    write_byte(8'h22, ak);
    write_byte(8'h33, ak);
    bus_stop;
    check("R3 strobes", wr_cnt - base, 3);
    check("R3 mem20", int'(mem[8'h20]), 'h33);
    check("R3 mem21 untouched", int'(mem[8'h21]), int'(seed(8'h21)));

    // R4: saturation on write
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'h7E, ak);
    write_byte(8'h71, ak);
    write_byte(8'h72, ak);
    write_byte(8'h73, ak);
    bus_stop;
    check("R4 mem126", int'(mem[126]), 'h71);
    check("R4 mem127 saturated", int'(mem[127]), 'h73);

    // R6 R8: bare read from zero
    base = rd_cnt;
    bus_start;
    write_byte({DEV, 1'b1}, ak);
    check("R6 read address ack", int'(ak), 1);
    for (int i = 0; i < 3; i++) begin
      read_byte(rv, i != 2);
      check("R6 bare read", int'(rv), int'(seed(i)));
    end
    bus_stop;
    check("R8 read strobes", rd_cnt - base, 3);

    // R7: write pointer, repeated start, read
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'h10, ak);
    bus_start;
    write_byte({DEV, 1'b1}, ak);
    read_byte(rv, 1'b1); check("R7 read 16", int'(rv), 'hA5);
    read_byte(rv, 1'b1); check("R7 read 17", int'(rv), 'h3C);
    read_byte(rv, 1'b0); check("R7 read 18", int'(rv), 'hE1);
    bus_stop;

    // R4: saturation on read
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'h7E, ak);
    bus_start;
    write_byte({DEV, 1'b1}, ak);
    read_byte(rv, 1'b1); check("R4 read 126", int'(rv), 'h71);
    read_byte(rv, 1'b1); check("R4 read 127", int'(rv), 'h73);
    read_byte(rv, 1'b0); check("R4 read 127 again", int'(rv), 'h73);
    bus_stop;

    // R9: NACK releases the line
    base = rd_cnt;
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'h40, ak);
    bus_start;
    write_byte({DEV, 1'b1}, ak);
    read_byte(rv, 1'b0);
    check("R9 first byte", int'(rv), int'(seed(8'h40)));
    read_byte(rv, 1'b0);
    check("R9 line released", int'(rv), 'hFF);
    check("R9 single strobe", rd_cnt - base, 1);
    bus_stop;

    // R5: stop clears pointer
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'h30, ak);
    write_byte(8'h99, ak);
    bus_stop;
    check("R5 mem30", int'(mem[8'h30]), 'h99);
    bus_start;
    write_byte({DEV, 1'b1}, ak);
    read_byte(rv, 1'b0);
    check("R5 pointer zero", int'(rv), int'(seed(0)));
    bus_stop;

    // R5: stop clears inhibit
    bus_start;
    write_byte({DEV, 1'b0}, ak);
    write_byte(8'h85, ak);
    bus_stop;
    bus_start;
    write_byte({DEV, 1'b1}, ak);
    read_byte(rv, 1'b1); check("R5 inhibit cleared 0", int'(rv), int'(seed(0)));
    read_byte(rv, 1'b0); check("R5 inhibit cleared 1", int'(rv), int'(seed(1)));
    bus_stop;
    check("R5 idle release", int'(sda_oe), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule